// File: doc/BRIEF.md
# Shared-Band Radio Coexistence Gate

This block sits between the link controller of a short-range radio and a collocated wireless LAN device that uses the same 2.4 GHz band. Every slot, the link controller raises a radio activity request with a priority level. The block answers with a registered permit that tells the radio whether it may transmit or receive in that slot. It also drives or samples a set of four shared coexistence pins, so that the two radios do not step on each other.

The meaning of the four pins depends on the coexistence scheme that the host selects. There are five schemes. In the arbitration scheme (the default after reset), the block sends a request with a priority and waits for a confirm. In the LAN-master scheme, the LAN device blocks the local radio. In the local-master scheme, the local radio announces its activity to block the LAN device. In the two-wire scheme, a host bit decides which side wins. In the alternating-medium scheme, the local radio may transmit or receive only while a medium-free line is high. Inbound lines pass through synchronizers. A change of scheme waits until the radio is idle and then inserts one forced-idle cycle.

Top module: `coex_gate`

## Requirements
- R1: After reset the active scheme is arbitration: permit is 0, pinOut is 4'b0000 and pinOe is 4'b1101.
- R2: Arbitration scheme (code 0). Pin 0 outputs the request. Pin 2 outputs the priority MSB and pin 3 outputs the priority LSB, both gated by the request. Pin 1 is the confirm input. Permit is 1 when the request is high and the synchronized confirm is high.
- R3: In the arbitration scheme, a request at priority 2'b11 (voice) is permitted without a confirm only when overrideEn is 1. A request at a lower priority, or with overrideEn at 0, still needs the confirm.
- R4: LAN-master scheme (code 1). Pin 0 is a blocking input, and while its synchronized value is 1 the permit is 0. Otherwise the permit follows the request. No pin is driven (pinOe 4'b0000).
- R5: Local-master scheme (code 2). Pin 1 is driven (pinOe 4'b0010) with the request, registered one cycle. The permit follows the request, and all inbound pins are disregarded.
- R6: Two-wire scheme (code 3). Pin 1 is driven with the request and pin 0 is the inbound block. With twoWireMaster at 1, pin 0 is disregarded. With twoWireMaster at 0, a synchronized 1 on pin 0 forces the permit to 0.
- R7: Alternating-medium scheme (code 4). Pin 0 high means the medium is free. The permit is 1 only when the request is high and the synchronized pin 0 is 1. No pin is driven.
- R8: Pins that the active scheme does not use have no effect on the permit, and they are never driven.
- R9: A new modeSel value is adopted only at a clock edge where the request and the permit are both 0. Codes 5 to 7 are ignored and the current scheme remains in force.
- R10: In the cycle in which a scheme change is applied, the permit and pinOut are forced to 0 even if a request is present.
- R11: Inbound pins pass through a two-stage synchronizer. A pin change made between edges is reflected in the permit after the third following edge, and not after the second.
- R12: The permit is registered. A change of the request appears on the permit after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Requested coexistence scheme code (0 to 4) |
| twoWireMaster | input | 1 | Two-wire scheme: 1 means the local side wins |
| overrideEn | input | 1 | Lets a voice-priority request proceed without confirm |
| req | input | 1 | Radio activity request for the slot |
| reqPrio | input | PRIO_W | Request priority, all ones means voice |
| pinIn | input | 4 | Sampled values of the shared coexistence pins |
| pinOut | output | 4 | Values driven onto the shared pins |
| pinOe | output | 4 | Output enable per shared pin |
| permit | output | 1 | Radio may transmit or receive |

## Verification
The hardest situation to reach is the forced-idle cycle of a scheme change that coincides with a new request. From the ports, the request must rise exactly one edge after the idle edge at which the new scheme was accepted. The bench sets modeSel at a falling edge while the radio is idle, raises the request at the next falling edge, and checks that the permit is 0 for one cycle before the new scheme grants it. A second hard case is a modeSel change while the radio is busy. The bench holds the request high and then drives a pin that only the old scheme reads, which shows at the ports that the old scheme is still in force.

// File: rtl/coex_pkg.sv
package coex_pkg;

  localparam int PIN_COUNT = 4;

  typedef enum logic [2:0] {
    MODE_ARB = 3'd0,
    MODE_LAN = 3'd1,
    MODE_BT  = 3'd2,
    MODE_TWO = 3'd3,
    MODE_ALT = 3'd4
  } coexMode_e;

  // Output enable pattern per scheme
  localparam logic [PIN_COUNT-1:0] OE_ARB  = 4'b1101;
  localparam logic [PIN_COUNT-1:0] OE_LAN  = 4'b0000;
  localparam logic [PIN_COUNT-1:0] OE_BT   = 4'b0010;
  localparam logic [PIN_COUNT-1:0] OE_TWO  = 4'b0010;
  localparam logic [PIN_COUNT-1:0] OE_ALT  = 4'b0000;

  // Strobes from control to datapath
  typedef struct packed {
    logic      holdOff;
    coexMode_e mode;
  } ctrlStrobe_t;

  function automatic logic isValidMode(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/coex_ctrl.sv
module coex_ctrl
  import coex_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeSel,
  input  logic        req,
  input  logic        permit,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_RUN, ST_SWITCH} ctrlState_e;

  ctrlState_e state;
  coexMode_e  activeMode;
  coexMode_e  pendMode;
  logic       wantSwitch;

  // A switch is accepted only on a valid, different code while idle
  assign wantSwitch = isValidMode(modeSel) && (modeSel != activeMode)
                      && !req && !permit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      activeMode <= MODE_ARB;
      pendMode   <= MODE_ARB;
    end else begin
      case (state)
        ST_RUN: begin
          if (wantSwitch) begin
            pendMode <= coexMode_e'(modeSel);
            state    <= ST_SWITCH;
          end
        end
        ST_SWITCH: begin
          activeMode <= pendMode;
          state      <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.holdOff = (state == ST_SWITCH);
    strobe.mode    = activeMode;
  end

endmodule

// File: rtl/coex_datapath.sv
module coex_datapath
  import coex_pkg::*;
#(
  parameter int PRIO_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic                 req,
  input  logic [PRIO_W-1:0]    reqPrio,
  input  logic                 twoWireMaster,
  input  logic                 overrideEn,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] syncPins,
  output logic                 permit
);

  localparam logic [PRIO_W-1:0] VOICE_PRIO = {PRIO_W{1'b1}};

  logic                 permitNext;
  logic [PIN_COUNT-1:0] pinOutNext;
  logic                 isVoice;

  coex_sync #(
    .WIDTH (PIN_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn),
    .dOut (syncPins)
  );

  assign isVoice = (reqPrio == VOICE_PRIO);

  always_comb begin
    permitNext = 1'b0;
    pinOutNext = '0;
    pinOe      = '0;
    case (strobe.mode)
      MODE_ARB: begin
        pinOe         = OE_ARB;
        pinOutNext[0] = req;
        pinOutNext[2] = req & reqPrio[PRIO_W-1];
        pinOutNext[3] = req & reqPrio[PRIO_W-2];
        permitNext    = req & (syncPins[1] | (overrideEn & isVoice));
      end
      MODE_LAN: begin
        pinOe      = OE_LAN;
        permitNext = req & ~syncPins[0];
      end
      MODE_BT: begin
        pinOe         = OE_BT;
        pinOutNext[1] = req;
        permitNext    = req;
      end
      MODE_TWO: begin
        pinOe         = OE_TWO;
        pinOutNext[1] = req;
        permitNext    = twoWireMaster ? req : (req & ~syncPins[0]);
      end
      MODE_ALT: begin
        pinOe      = OE_ALT;
        permitNext = req & syncPins[0];
      end
      default: begin
        pinOe = '0;
      end
    endcase
    if (strobe.holdOff) begin
      permitNext = 1'b0;
      pinOutNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permit <= 1'b0;
      pinOut <= '0;
    end else begin
      permit <= permitNext;
      pinOut <= pinOutNext;
    end
  end

endmodule

// File: rtl/coex_gate.sv
module coex_gate
  import coex_pkg::*;
#(
  parameter int PRIO_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              twoWireMaster,
  input  logic              overrideEn,
  input  logic              req,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [3:0]        pinIn,
  output logic [3:0]        pinOut,
  output logic [3:0]        pinOe,
  output logic              permit
);

  ctrlStrobe_t strobe;
  logic [3:0]  syncPins;
  logic [2:0]  activeModeW;

  assign activeModeW = strobe.mode;

  coex_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .req     (req),
    .permit  (permit),
    .strobe  (strobe)
  );

  coex_datapath #(
    .PRIO_W      (PRIO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .req           (req),
    .reqPrio       (reqPrio),
    .twoWireMaster (twoWireMaster),
    .overrideEn    (overrideEn),
    .pinIn         (pinIn),
    .pinOut        (pinOut),
    .pinOe         (pinOe),
    .syncPins      (syncPins),
    .permit        (permit)
  );

endmodule

// File: rtl/coex_gate_chk.sv
module coex_gate_chk
  import coex_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       req,
  input logic       permit,
  input logic [3:0] pinOut,
  input logic [3:0] syncPins,
  input logic [2:0] activeMode
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R12: a permit is only ever granted for a request seen one edge earlier
  p_permit_needs_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    (armed && permit) |-> $past(req));

  // R4: synchronized LAN block suppresses the next permit
  p_lan_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == MODE_LAN && syncPins[0]) |=> !permit);

  // R7: no permit while the medium is not free
  p_alt_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == MODE_ALT && !syncPins[0]) |=> !permit);

  // R10: the cycle a new scheme appears carries no permit
  p_switch_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && activeMode != $past(activeMode)) |-> !permit);

  // R5: local-master pin follows the request with one register
  p_bt_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && activeMode == MODE_BT && $past(activeMode) == MODE_BT)
      |-> pinOut[1] == $past(req));

  // R2: arbitration request pin follows the request with one register
  p_arb_req_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && activeMode == MODE_ARB && $past(activeMode) == MODE_ARB)
      |-> pinOut[0] == $past(req));

endmodule

bind coex_gate coex_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .req        (req),
  .permit     (permit),
  .pinOut     (pinOut),
  .syncPins   (syncPins),
  .activeMode (activeModeW)
);

// File: tb/tb_coex_gate.sv
`timescale 1ns/1ps
module tb_coex_gate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic       twoWireMaster = 1'b0;
  logic       overrideEn = 1'b0;
  logic       req = 1'b0;
  logic [1:0] reqPrio = 2'b00;
  logic [3:0] pinIn = 4'b0000;
  logic [3:0] pinOut;
  logic [3:0] pinOe;
  logic       permit;

  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic       permit;
    logic [3:0] out;
    logic [3:0] oe;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  always #2 clk = ~clk;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  coex_gate dut (
    .clk           (clk),
    .rstN          (rstN),
    .modeSel       (modeSel),
    .twoWireMaster (twoWireMaster),
    .overrideEn    (overrideEn),
    .req           (req),
    .reqPrio       (reqPrio),
    .pinIn         (pinIn),
    .pinOut        (pinOut),
    .pinOe         (pinOe),
    .permit        (permit)
  );

  // Driver side: queue an expectation for the current sampling point
  task automatic expectNow(input logic p, input logic [3:0] o,
                           input logic [3:0] e, input string tag);
    exp_t item;
    item.due    = cycleCnt;
    item.permit = p;
    item.out    = o;
    item.oe     = e;
    item.tag    = tag;
    sbq.push_back(item);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations shortly after the falling edge
  always @(negedge clk) begin : monitor
    exp_t cur;
    #1;
    while (sbq.size() > 0 && sbq[0].due <= cycleCnt) begin
      cur = sbq.pop_front();
      checks++;
      if (permit !== cur.permit || pinOut !== cur.out || pinOe !== cur.oe) begin
        fails++;
        $display("FAIL %s: permit/pinOut/pinOe got %b/%b/%b expected %b/%b/%b",
                 cur.tag, permit, pinOut, pinOe, cur.permit, cur.out, cur.oe);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    expectNow(1'b0, 4'b0000, 4'b1101, "R1 reset state");
    step(1);
    rstN = 1'b1;

    // Arbitration scheme
    req = 1'b1; reqPrio = 2'b10; pinIn = 4'b0000;
    step(1);
    expectNow(1'b0, 4'b0101, 4'b1101, "R2 request pins, no confirm");
    pinIn = 4'b0010;
    step(4);
    expectNow(1'b1, 4'b0101, 4'b1101, "R2 confirm grants");
    pinIn = 4'b0000; reqPrio = 2'b11;
    step(4);
    expectNow(1'b0, 4'b1101, 4'b1101, "R3 voice without override bit");
    overrideEn = 1'b1;
    step(1);
    expectNow(1'b1, 4'b1101, 4'b1101, "R3 voice override");
    reqPrio = 2'b10;
    step(1);
    expectNow(1'b0, 4'b0101, 4'b1101, "R3 low prio still needs confirm");

    // To LAN-master
    req = 1'b0; overrideEn = 1'b0; modeSel = 3'd1;
    step(5);
    expectNow(1'b0, 4'b0000, 4'b0000, "R4 LAN scheme adopted");
    req = 1'b1;
    step(1);
    expectNow(1'b1, 4'b0000, 4'b0000, "R12 permit one edge after request");
    pinIn = 4'b0001;
    step(2);
    expectNow(1'b1, 4'b0000, 4'b0000, "R11 block not yet through synchronizer");
    step(1);
    expectNow(1'b0, 4'b0000, 4'b0000, "R11 R4 block after sync");
    pinIn = 4'b1110;
    step(3);
    expectNow(1'b1, 4'b0000, 4'b0000, "R8 unused pins ignored in LAN");

    // Change requested while busy: must not be taken
    modeSel = 3'd2;
    step(5);
    expectNow(1'b1, 4'b0000, 4'b0000, "R9 busy keeps scheme");
    pinIn = 4'b1111;
    step(3);
    expectNow(1'b0, 4'b0000, 4'b0000, "R9 old LAN block still obeyed");
    req = 1'b0;
    step(5);
    expectNow(1'b0, 4'b0000, 4'b0010, "R9 switch once idle");
    req = 1'b1;
    step(1);
    expectNow(1'b1, 4'b0010, 4'b0010, "R5 local master drives pin 1");
    req = 1'b0;
    step(1);
    expectNow(1'b0, 4'b0000, 4'b0010, "R5 pin 1 released");

    // Forced idle cycle during switch to two-wire
    modeSel = 3'd3; twoWireMaster = 1'b1; pinIn = 4'b0001;
    step(1);
    req = 1'b1;
    step(1);
    expectNow(1'b0, 4'b0000, 4'b0010, "R10 forced idle in switch cycle");
    step(1);
    expectNow(1'b1, 4'b0010, 4'b0010, "R6 two-wire master ignores pin 0");
    twoWireMaster = 1'b0;
    step(2);
    expectNow(1'b0, 4'b0010, 4'b0010, "R6 two-wire slave blocked");
    pinIn = 4'b0000;
    step(3);
    expectNow(1'b1, 4'b0010, 4'b0010, "R6 two-wire slave clear");

    // Invalid code, then alternating medium
    req = 1'b0; modeSel = 3'd6;
    step(5);
    expectNow(1'b0, 4'b0000, 4'b0010, "R9 invalid code ignored");
    modeSel = 3'd4;
    step(5);
    expectNow(1'b0, 4'b0000, 4'b0000, "R7 alternating adopted");
    req = 1'b1; pinIn = 4'b1110;
    step(3);
    expectNow(1'b0, 4'b0000, 4'b0000, "R7 R8 medium busy, other pins high");
    pinIn = 4'b0001;
    step(3);
    expectNow(1'b1, 4'b0000, 4'b0000, "R7 medium free");
    req = 1'b0;
    step(1);
    expectNow(1'b0, 4'b0000, 4'b0000, "R12 permit drops one edge later");

    // Back to arbitration
    modeSel = 3'd0;
    step(5);
    expectNow(1'b0, 4'b0000, 4'b1101, "R9 return to arbitration");

    step(3);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule